// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Peripheral Pin Takeover

This block is an 8-bit general-purpose I/O port. It holds a data latch and a direction register, and both are reached over a single-cycle register bus. For every pin it drives an output-enable and an output value to the pad. It also samples each pad level through a two-flop synchronizer.

Four pins can be taken over by on-chip peripherals. Pin 0 carries serial transmit data and pin 1 carries serial receive data, both while the serial-enable input is high. Pins 2 and 3 carry timer channels 0 and 1, each while that channel's two-bit mode field is non-zero. While a peripheral owns a pin, the peripheral sets the pin's direction and drive. The port read path still uses the direction bit to choose between the latch and the synchronized pin level.

The block has no control state machine. Its only sequential state is the two registers and the synchronizer stages, so there are no states or transitions to list.

Top module: `gpio_port_ovr`

## Requirements
- R1: After reset the direction register and the data latch both read 0x00, and with no peripheral enabled every pad_oe bit is 0.
- R2: The direction register sits at address 0x0C. A write there stores bus_wdata, and a read there returns the stored value in the same cycle.
- R3: On a pin no peripheral owns, pad_oe equals the pin's direction bit (1 = output) and pad_out equals its latch bit.
- R4: A read at address 0x08 returns, bit by bit, the latch value where the direction bit is 1 and the synchronized pad level where it is 0.
- R5: A change on pad_in first shows in the read data, ser_rxd and tmr_in after the second rising clock edge that follows it.
- R6: While ser_en is 1, pin 0 has pad_oe=1 and pad_out=ser_txd, whatever its direction bit holds.
- R7: While ser_en is 1, pin 1 has pad_oe=0. ser_rxd always carries the synchronized level of pin 1.
- R8: Timer channel k owns pin 2+k exactly when tmr{k}_mode is non-zero. It then sets pad_oe from tmr_oe[k] and pad_out from tmr_out[k]. Mode 00 leaves the pin as general-purpose I/O. tmr_in[k] always carries the synchronized level of pin 2+k.
- R9: The read rule of R4 still applies to pins that a peripheral owns.
- R10: A write to address 0x08 always updates the latch, including bits that are inputs or peripheral-owned. The stored value reaches the pad once the pin becomes a general-purpose output.
- R11: Writes to any address other than 0x08 and 0x0C change neither register, and reads from those addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pad_in | input | 8 | Pad levels, asynchronous |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin drive value |
| ser_en | input | 1 | Serial peripheral owns pins 0 and 1 |
| ser_txd | input | 1 | Serial transmit data |
| ser_rxd | output | 1 | Synchronized pin-1 level for the serial receiver |
| tmr0_mode | input | 2 | Channel 0 edge/level select, non-zero owns pin 2 |
| tmr1_mode | input | 2 | Channel 1 edge/level select, non-zero owns pin 3 |
| tmr_oe | input | 2 | Timer channel drive enables |
| tmr_out | input | 2 | Timer channel drive values |
| tmr_in | output | 2 | Synchronized pin levels of pins 3 and 2 |

## Verification
The assertions assume that reset is applied at the start. The synchronizer latency check only runs once three clocks have passed since reset, so it never sees levels from the reset period. They also assume that bus_addr and bus_we are known at every rising edge. The bench changes all inputs, pad levels included, only at falling edges. It holds each random pad pattern for at least two rising edges before it compares read data against the pad pattern.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
    localparam int unsigned ADDR_W   = 8;
    localparam logic [7:0]  ADDR_DAT = 8'h08;
    localparam logic [7:0]  ADDR_DIR = 8'h0C;
    localparam int unsigned PIN_TXD  = 0;
    localparam int unsigned PIN_RXD  = 1;
    localparam int unsigned PIN_TCH0 = 2;
    localparam int unsigned TMR_CH   = 2;

    typedef struct packed {
        logic [7:0] own;
        logic [7:0] oe;
        logic [7:0] drv;
    } pin_take_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        stage_q[0] <= d_in;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign q_out = stage_q[STAGES-1];

    // cycles since reset release, used to gate the latency check
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               warm_q <= '0;
        else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;
    end

    generate
        if (STAGES == 2) begin : g_chk
            assert_sync_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (warm_q == 2'd3) |-> (q_out == $past(d_in, 2)));
        end
    endgenerate
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_ovr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [WIDTH-1:0]  pin_lvl,
    output logic [WIDTH-1:0]  rdata,
    output logic [WIDTH-1:0]  latch_q,
    output logic [WIDTH-1:0]  dir_q
);
    logic hit_dat, hit_dir;
    assign hit_dat = (addr == ADDR_DAT);
    assign hit_dir = (addr == ADDR_DIR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
        end else if (we) begin
            if (hit_dat) latch_q <= wdata;
            if (hit_dir) dir_q   <= wdata;
        end
    end

    logic [WIDTH-1:0] port_view;
    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_view
            assign port_view[b] = dir_q[b] ? latch_q[b] : pin_lvl[b];
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (hit_dat)      rdata = port_view;
        else if (hit_dir) rdata = dir_q;
    end

    assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit_dir) |=> (dir_q == $past(wdata)));
    assert_latch_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit_dat) |=> (latch_q == $past(wdata)));
    assert_latch_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && hit_dat) |=> $stable(latch_q));
    assert_dir_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && hit_dir) |=> $stable(dir_q));
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
    import gpio_ovr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] latch_q,
    input  pin_take_t        take,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out
);
    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_pin
            assign pad_oe[b]  = take.own[b] ? take.oe[b]  : dir_q[b];
            assign pad_out[b] = take.own[b] ? take.drv[b] : latch_q[b];
        end
    endgenerate
endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr
    import gpio_ovr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_out,
    input  logic              ser_en,
    input  logic              ser_txd,
    output logic              ser_rxd,
    input  logic [1:0]        tmr0_mode,
    input  logic [1:0]        tmr1_mode,
    input  logic [TMR_CH-1:0] tmr_oe,
    input  logic [TMR_CH-1:0] tmr_out,
    output logic [TMR_CH-1:0] tmr_in
);
    logic [WIDTH-1:0] pin_lvl, latch_q, dir_q;
    pin_take_t        take;
    logic [TMR_CH-1:0] tmr_own;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(pad_in), .q_out(pin_lvl)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
        .wdata(bus_wdata), .pin_lvl(pin_lvl), .rdata(bus_rdata),
        .latch_q(latch_q), .dir_q(dir_q)
    );

    assign tmr_own[0] = (tmr0_mode != 2'b00);
    assign tmr_own[1] = (tmr1_mode != 2'b00);

    always_comb begin
        take = '0;
        take.own[PIN_TXD] = ser_en;
        take.oe[PIN_TXD]  = 1'b1;
        take.drv[PIN_TXD] = ser_txd;
        take.own[PIN_RXD] = ser_en;
        for (int k = 0; k < TMR_CH; k++) begin
            take.own[PIN_TCH0+k] = tmr_own[k];
            take.oe[PIN_TCH0+k]  = tmr_oe[k];
            take.drv[PIN_TCH0+k] = tmr_out[k];
        end
    end

    gpio_pinmux #(.WIDTH(WIDTH)) u_mux (
        .dir_q(dir_q), .latch_q(latch_q), .take(take),
        .pad_oe(pad_oe), .pad_out(pad_out)
    );

    assign ser_rxd = pin_lvl[PIN_RXD];
    assign tmr_in  = pin_lvl[PIN_TCH0 +: TMR_CH];

    assert_gpio_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_en && !tmr_own[0] && !tmr_own[1]) |->
        (pad_oe == dir_q && pad_out == latch_q));
    assert_tx_forced_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ser_en |-> (pad_oe[PIN_TXD] && pad_out[PIN_TXD] == ser_txd));
    assert_rx_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ser_en |-> !pad_oe[PIN_RXD]);
    assert_tmr_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr0_mode == 2'b00) |-> (pad_oe[PIN_TCH0] == dir_q[PIN_TCH0]));
    assert_upper_gpio_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (pad_oe[WIDTH-1:4] == dir_q[WIDTH-1:4]));
endmodule

// File: tb/gpio_port_ovr_bench.sv
`timescale 1ns/1ps
module gpio_port_ovr_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_oe, pad_out;
    logic       ser_en = 1'b0, ser_txd = 1'b0, ser_rxd;
    logic [1:0] tmr0_mode = 2'b00, tmr1_mode = 2'b00;
    logic [1:0] tmr_oe = 2'b00, tmr_out = 2'b00, tmr_in;

    int checks = 0;
    int bad = 0;
    logic [7:0] m_dir = 8'h00, m_lat = 8'h00;

    always #2 clk = ~clk;

    gpio_port_ovr u_gpio_port_ovr (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .ser_en(ser_en), .ser_txd(ser_txd),
        .ser_rxd(ser_rxd), .tmr0_mode(tmr0_mode), .tmr1_mode(tmr1_mode),
        .tmr_oe(tmr_oe), .tmr_out(tmr_out), .tmr_in(tmr_in)
    );

    function automatic logic [7:0] own_mask();
        return {4'h0, tmr1_mode != 2'b00, tmr0_mode != 2'b00, ser_en, ser_en};
    endfunction
    function automatic logic [7:0] exp_oe();
        logic [7:0] o = m_dir;
        if (ser_en) begin o[0] = 1'b1; o[1] = 1'b0; end
        if (tmr0_mode != 2'b00) o[2] = tmr_oe[0];
        if (tmr1_mode != 2'b00) o[3] = tmr_oe[1];
        return o;
    endfunction
    function automatic logic [7:0] exp_out();
        logic [7:0] o = m_lat;
        if (ser_en) begin o[0] = ser_txd; o[1] = 1'b0; end
        if (tmr0_mode != 2'b00) o[2] = tmr_out[0];
        if (tmr1_mode != 2'b00) o[3] = tmr_out[1];
        return o;
    endfunction
    function automatic logic [7:0] exp_rd(input logic [7:0] pins);
        return (m_dir & m_lat) | (~m_dir & pins);
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] want);
        checks++;
        if (got !== want) begin
            bad++;
            $display("FAIL %s got=%02h exp=%02h", tag, got, want);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
        if (a == 8'h08) m_lat = d;
        if (a == 8'h0C) m_dir = d;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] want);
        @(negedge clk);
        bus_addr = a;
        #1 chk(tag, bus_rdata, want);
    endtask

    initial begin
        #400000;
        checks++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0017));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 oe", pad_oe, 8'h00);
        rd_chk("R1 dir", 8'h0C, 8'h00);
        chk("R1 out", pad_out, 8'h00);

        // R2 direction register
        wr(8'h0C, 8'hA5);
        rd_chk("R2 dir readback", 8'h0C, 8'hA5);
        // R3 gpio drive, R10 latch write
        wr(8'h08, 8'h3C);
        #1 chk("R3 oe", pad_oe, 8'hA5);
        chk("R3 out", pad_out, 8'h3C);

        // R5 two-edge latency on pins that are inputs
        wr(8'h0C, 8'h00);
        @(negedge clk); pad_in = 8'h00; bus_addr = 8'h08;
        repeat (3) @(posedge clk);
        @(negedge clk); pad_in = 8'hFF;
        @(posedge clk); #1 chk("R5 after one edge", bus_rdata, 8'h00);
        @(posedge clk); #1 chk("R5 after two edges", bus_rdata, 8'hFF);
        chk("R5 rxd", {7'h0, ser_rxd}, 8'h01);

        // R11 unmapped address
        wr(8'h04, 8'h77);
        wr(8'h0D, 8'h11);
        rd_chk("R11 dir unchanged", 8'h0C, 8'h00);
        wr(8'h0C, 8'hFF);
        rd_chk("R11 latch unchanged", 8'h08, 8'h3C);
        rd_chk("R11 unmapped read", 8'h10, 8'h00);

        // R10 latch written while pins are inputs, then revealed
        wr(8'h0C, 8'h00);
        wr(8'h08, 8'h96);
        #1 chk("R10 hidden", pad_oe, 8'h00);
        wr(8'h0C, 8'hFF);
        #1 chk("R10 revealed", pad_out, 8'h96);

        // R6/R7 serial takeover, R9 read follows dir on owned pins
        @(negedge clk); ser_en = 1'b1; ser_txd = 1'b0; pad_in = 8'h02;
        repeat (2) @(posedge clk);
        #1 chk("R6 tx oe forced", {7'h0, pad_oe[0]}, 8'h01);
        chk("R6 tx data", {7'h0, pad_out[0]}, 8'h00);
        chk("R7 rx input", {7'h0, pad_oe[1]}, 8'h00);
        rd_chk("R9 owned reads latch", 8'h08, 8'h96);
        wr(8'h0C, 8'h00);
        rd_chk("R9 owned reads pin", 8'h08, 8'h02);
        #1 chk("R6 tx oe with dir 0", {7'h0, pad_oe[0]}, 8'h01);
        @(negedge clk); ser_en = 1'b0;

        // R8 timer mode 00 vs non-zero
        @(negedge clk); tmr0_mode = 2'b00; tmr_oe = 2'b11; tmr_out = 2'b11;
        #1 chk("R8 mode00 gpio", {7'h0, pad_oe[2]}, 8'h00);
        @(negedge clk); tmr0_mode = 2'b10; tmr1_mode = 2'b01;
        #1 chk("R8 owned oe", {6'h0, pad_oe[3:2]}, 8'h03);
        chk("R8 owned out", {6'h0, pad_out[3:2]}, 8'h03);
        @(negedge clk); tmr0_mode = 2'b00; tmr1_mode = 2'b00;

        // random mix
        for (int it = 0; it < 300; it++) begin
            logic [7:0] pins;
            pins = 8'($urandom);
            @(negedge clk);
            pad_in = pins;
            ser_en = 1'($urandom); ser_txd = 1'($urandom);
            tmr0_mode = 2'($urandom); tmr1_mode = 2'($urandom);
            tmr_oe = 2'($urandom); tmr_out = 2'($urandom);
            wr(8'h0C, 8'($urandom));
            wr(8'h08, 8'($urandom));
            @(posedge clk); #1;
            chk("R3/R6/R8 rand oe", pad_oe, exp_oe());
            chk("R3/R6/R8 rand out", pad_out, exp_out());
            chk("R7 rand rxd", {7'h0, ser_rxd}, {7'h0, pins[1]});
            chk("R8 rand tmr_in", {6'h0, tmr_in}, {6'h0, pins[3:2]});
            if (own_mask() != 8'h00)
                rd_chk("R9 rand read", 8'h08, exp_rd(pins));
            else
                rd_chk("R4 rand read", 8'h08, exp_rd(pins));
            rd_chk("R2 rand dir", 8'h0C, m_dir);
        end

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule